// File: doc/BRIEF.md
# Branch Target Buffer with Penalty Reporting

This block sits beside the fetch stage. The fetch PC indexes a small direct-mapped table in the same cycle. When the indexed entry is valid and its stored address matches, the block reports a predicted-taken branch and offers the stored destination as the next fetch address. In every other case fetch simply moves on to PC+4. Only branches that were actually taken are ever held in the table.

When a branch resolves later in the pipeline, the block takes four things: the branch PC, the real direction, the real target, and whether the lookup hit at fetch time. From these it sorts the branch into one outcome class. The class decides what happens next:

- whether an entry is written, retargeted or removed,
- whether a redirect (kill and refetch) is raised, and to which address,
- how many cycles the branch cost: 0 or 2.

Direction counters and the kill of fetched work belong to neighbouring logic.

Top module: `btb_penalty_unit`

## Requirements
- R1: While rst_ni is low and after it is released, every entry is invalid, so pred_hit_o is 0 and pred_next_pc_o is fetch_pc_i+4 for any fetch PC.
- R2: The lookup is combinational in the fetch cycle. If the entry at index fetch_pc_i[5:2] is valid and its stored tag equals the remaining PC bits ([31:6] and [1:0]), pred_hit_o is 1 and pred_next_pc_o is the stored target.
- R3: On a lookup miss, pred_hit_o is 0 and pred_next_pc_o is fetch_pc_i+4.
- R4: A resolve with res_hit_i=0 and res_taken_i=1 writes the entry (valid, tag of res_pc_i, res_target_i), raises redirect_o with redirect_pc_o = res_target_i, and reports penalty 2.
- R5: A resolve with res_hit_i=1 and res_taken_i=1 raises no redirect and reports penalty 0, provided the entry still matches res_pc_i and its stored target equals res_target_i. The entry is left unchanged.
- R6: A resolve with res_hit_i=1 and res_taken_i=1 is a retarget when the stored target differs from res_target_i (or the entry no longer matches). The entry is rewritten with res_target_i, redirect_pc_o = res_target_i, and the penalty is 2.
- R7: A resolve with res_hit_i=1 and res_taken_i=0 raises redirect_o with redirect_pc_o = res_pc_i+4, reports penalty 2, and invalidates the matching entry.
- R8: A resolve with res_hit_i=0 and res_taken_i=0 raises no redirect, reports penalty 0, and leaves the table unchanged.
- R9: The resolve outputs are combinational. penalty_valid_o equals res_valid_i, and penalty_o gives the cycle count (encoded 0 or 2). When res_valid_i is 0, redirect_o is 0 and the table is not touched, whatever the other resolve inputs are.
- R10: A table change made by a resolve becomes visible to lookups from the next rising clock edge. A lookup in the same cycle still sees the old contents.
- R11: Two branches with the same index but different tags replace one another. A PC that differs from a stored one in any tag bit, including bits [1:0], misses.
- R12: A not-taken resolve of a branch whose entry was since replaced by another branch still redirects with penalty 2, but does not remove the other branch's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | 32 | Fetch address to look up |
| pred_hit_o | output | 1 | Lookup found a stored taken branch |
| pred_next_pc_o | output | 32 | Predicted next fetch address |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | 32 | Address of the resolving branch |
| res_taken_i | input | 1 | Actual direction, 1 = taken |
| res_hit_i | input | 1 | The branch hit in the table at fetch |
| res_target_i | input | 32 | Actual taken target |
| redirect_o | output | 1 | Kill fetched work and refetch |
| redirect_pc_o | output | 32 | Correct fetch address on redirect |
| penalty_valid_o | output | 1 | penalty_o is meaningful |
| penalty_o | output | 2 | Cycles lost by this branch, 0 or 2 |

## Verification
A wrong stored tag, target or valid bit only shows up when that index is looked up again. From the next cycle on, it appears as a wrong pred_hit_o or pred_next_pc_o, or as a wrong redirect and penalty class on the next resolve of that branch. The vectors therefore follow every table change with a lookup of the same PC one cycle later, and also check the same-cycle lookup that must still see old contents. Conflicting branches that share an index cover replacement and stale deletes. Lookups of PCs that differ only in the low tag bits cover tag comparison.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned PEN_W = 2;
  localparam logic [PEN_W-1:0] PEN_NONE  = PEN_W'(0);
  localparam logic [PEN_W-1:0] PEN_FLUSH = PEN_W'(2);

  typedef struct packed {
    logic wr;
    logic clr;
  } tbl_op_t;
endpackage

// File: rtl/btb_entry.sv
module btb_entry #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned TAG_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             clr_en_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [PC_W-1:0]  target_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [PC_W-1:0]  target_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      tag_o    <= '0;
      target_o <= '0;
    end else if (clr_en_i) begin
      valid_o <= 1'b0;
    end else if (wr_en_i) begin
      valid_o  <= 1'b1;
      tag_o    <= tag_i;
      target_o <= target_i;
    end
  end

  // R6
  wr_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && clr_en_i));

  // R10
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_o && tag_o == $past(tag_i) && target_o == $past(target_i));

  // R7
  clr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !valid_o);
endmodule

// File: rtl/btb_resolve_ctl.sv
module btb_resolve_ctl
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned TAG_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic             res_taken_i,
  input  logic             res_hit_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic [TAG_W-1:0] res_tag_i,
  input  logic [PC_W-1:0]  res_target_i,
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [PC_W-1:0]  ent_target_i,
  output tbl_op_t          op_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic             penalty_valid_o,
  output logic [PEN_W-1:0] penalty_o
);
  logic tag_match;
  assign tag_match = ent_valid_i && (ent_tag_i == res_tag_i);

  always_comb begin
    op_o          = '0;
    redirect_o    = 1'b0;
    redirect_pc_o = '0;
    penalty_o     = PEN_NONE;
    if (res_valid_i) begin
      unique case ({res_hit_i, res_taken_i})
        2'b00: ; // not a known branch, fell through: free
        2'b01: begin
          op_o.wr       = 1'b1;
          redirect_o    = 1'b1;
          redirect_pc_o = res_target_i;
          penalty_o     = PEN_FLUSH;
        end
        2'b11: begin
          if (!(tag_match && ent_target_i == res_target_i)) begin
            op_o.wr       = 1'b1;
            redirect_o    = 1'b1;
            redirect_pc_o = res_target_i;
            penalty_o     = PEN_FLUSH;
          end
        end
        default: begin
          op_o.clr      = tag_match; // leave a conflicting branch alone
          redirect_o    = 1'b1;
          redirect_pc_o = res_pc_i + PC_W'(4);
          penalty_o     = PEN_FLUSH;
        end
      endcase
    end
  end

  assign penalty_valid_o = res_valid_i;

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |-> !redirect_o && !op_o.wr && !op_o.clr);

  // R8
  miss_nt_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_hit_i && !res_taken_i) |->
      !redirect_o && penalty_o == PEN_NONE && !op_o.wr && !op_o.clr);

  // R4
  redirect_cost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> penalty_valid_o && penalty_o == PEN_FLUSH);

  // R5
  hit_taken_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_taken_i && penalty_o == PEN_NONE) |-> res_hit_i && !op_o.wr);
endmodule

// File: rtl/btb_penalty_unit.sv
module btb_penalty_unit
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  fetch_pc_i,
  output logic             pred_hit_o,
  output logic [PC_W-1:0]  pred_next_pc_o,
  input  logic             res_valid_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic             res_taken_i,
  input  logic             res_hit_i,
  input  logic [PC_W-1:0]  res_target_i,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic             penalty_valid_o,
  output logic [PEN_W-1:0] penalty_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = PC_W - IDX_W;

  logic [IDX_W-1:0] fetch_idx, res_idx;
  logic [TAG_W-1:0] fetch_tag, res_tag;

  // index skips the two alignment bits; they stay in the tag
  assign fetch_idx = fetch_pc_i[IDX_W+1:2];
  assign res_idx   = res_pc_i[IDX_W+1:2];
  assign fetch_tag = {fetch_pc_i[PC_W-1:IDX_W+2], fetch_pc_i[1:0]};
  assign res_tag   = {res_pc_i[PC_W-1:IDX_W+2], res_pc_i[1:0]};

  logic             ent_valid  [ENTRIES];
  logic [TAG_W-1:0] ent_tag    [ENTRIES];
  logic [PC_W-1:0]  ent_target [ENTRIES];
  tbl_op_t          op;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = (res_idx == IDX_W'(g));
    btb_entry #(.PC_W(PC_W), .TAG_W(TAG_W)) u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (op.wr && sel),
      .clr_en_i (op.clr && sel),
      .tag_i    (res_tag),
      .target_i (res_target_i),
      .valid_o  (ent_valid[g]),
      .tag_o    (ent_tag[g]),
      .target_o (ent_target[g])
    );
  end

  assign pred_hit_o     = ent_valid[fetch_idx] && (ent_tag[fetch_idx] == fetch_tag);
  assign pred_next_pc_o = pred_hit_o ? ent_target[fetch_idx] : fetch_pc_i + PC_W'(4);

  btb_resolve_ctl #(.PC_W(PC_W), .TAG_W(TAG_W)) u_ctl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .res_valid_i     (res_valid_i),
    .res_taken_i     (res_taken_i),
    .res_hit_i       (res_hit_i),
    .res_pc_i        (res_pc_i),
    .res_tag_i       (res_tag),
    .res_target_i    (res_target_i),
    .ent_valid_i     (ent_valid[res_idx]),
    .ent_tag_i       (ent_tag[res_idx]),
    .ent_target_i    (ent_target[res_idx]),
    .op_o            (op),
    .redirect_o      (redirect_o),
    .redirect_pc_o   (redirect_pc_o),
    .penalty_valid_o (penalty_valid_o),
    .penalty_o       (penalty_o)
  );

  // R10
  ins_then_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.wr && fetch_pc_i == res_pc_i) |=>
      (fetch_pc_i != $past(fetch_pc_i)) || (pred_hit_o && pred_next_pc_o == $past(res_target_i)));
endmodule

// File: tb/btb_penalty_unit_test.sv
module btb_penalty_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] pred_next_pc;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic        res_hit = 1'b0;
  logic [31:0] res_target = '0;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic        penalty_valid;
  logic [1:0]  penalty;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  btb_penalty_unit uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_pc_i(fetch_pc), .pred_hit_o(pred_hit), .pred_next_pc_o(pred_next_pc),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_hit_i(res_hit), .res_target_i(res_target),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .penalty_valid_o(penalty_valid), .penalty_o(penalty)
  );

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        rtk;
    logic        rhit;
    logic [31:0] rtgt;
    logic [31:0] fpc;
    logic        ehit;
    logic [31:0] enext;
    logic        erdr;
    logic [31:0] erpc;
    logic [1:0]  epen;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h100, 1'b0, 32'h104, 1'b0, 32'h000, 2'd0}, // R3 empty
    '{1'b1, 32'h100, 1'b1, 1'b0, 32'h200, 32'h100, 1'b0, 32'h104, 1'b1, 32'h200, 2'd2}, // R4, R10 old view
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h100, 1'b1, 32'h200, 1'b0, 32'h000, 2'd0}, // R2
    '{1'b1, 32'h100, 1'b1, 1'b1, 32'h200, 32'h104, 1'b0, 32'h108, 1'b0, 32'h000, 2'd0}, // R5
    '{1'b1, 32'h100, 1'b1, 1'b1, 32'h240, 32'h100, 1'b1, 32'h200, 1'b1, 32'h240, 2'd2}, // R6, R10
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h100, 1'b1, 32'h240, 1'b0, 32'h000, 2'd0}, // R6 retargeted
    '{1'b1, 32'h104, 1'b0, 1'b0, 32'h000, 32'h104, 1'b0, 32'h108, 1'b0, 32'h000, 2'd0}, // R8
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h104, 1'b0, 32'h108, 1'b0, 32'h000, 2'd0}, // R8 unchanged
    '{1'b1, 32'h140, 1'b1, 1'b0, 32'h300, 32'h140, 1'b0, 32'h144, 1'b1, 32'h300, 2'd2}, // R11 conflict insert
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h100, 1'b0, 32'h104, 1'b0, 32'h000, 2'd0}, // R11 replaced
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h140, 1'b1, 32'h300, 1'b0, 32'h000, 2'd0}, // R11
    '{1'b1, 32'h100, 1'b0, 1'b1, 32'h000, 32'h140, 1'b1, 32'h300, 1'b1, 32'h104, 2'd2}, // R12 stale
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h140, 1'b1, 32'h300, 1'b0, 32'h000, 2'd0}, // R12 kept
    '{1'b1, 32'h140, 1'b0, 1'b1, 32'h000, 32'h140, 1'b1, 32'h300, 1'b1, 32'h144, 2'd2}, // R7
    '{1'b0, 32'h000, 1'b0, 1'b0, 32'h000, 32'h140, 1'b0, 32'h144, 1'b0, 32'h000, 2'd0}  // R7 deleted
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [31:0] rpc, input logic rtk,
                       input logic rhit, input logic [31:0] rtgt, input logic [31:0] fpc);
    res_valid = rv; res_pc = rpc; res_taken = rtk; res_hit = rhit;
    res_target = rtgt; fetch_pc = fpc;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    // R1: lookups miss while held in reset
    drive(1'b0, '0, 1'b0, 1'b0, '0, 32'h100);
    #5;
    check("R1 hit in reset", {31'b0, pred_hit}, 32'd0);
    check("R1 next in reset", pred_next_pc, 32'h104);
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #2 drive(VECS[i].rv, VECS[i].rpc, VECS[i].rtk, VECS[i].rhit, VECS[i].rtgt, VECS[i].fpc);
      #9;
      check($sformatf("R2 R3 R10 hit v%0d", i), {31'b0, pred_hit}, {31'b0, VECS[i].ehit});
      check($sformatf("R2 R3 R10 next v%0d", i), pred_next_pc, VECS[i].enext);
      check($sformatf("R9 pvalid v%0d", i), {31'b0, penalty_valid}, {31'b0, VECS[i].rv});
      check($sformatf("R4 R5 R6 R7 R8 R12 redirect v%0d", i), {31'b0, redirect}, {31'b0, VECS[i].erdr});
      if (VECS[i].rv) begin
        check($sformatf("R4 R5 R6 R7 R8 R12 penalty v%0d", i), {30'b0, penalty}, {30'b0, VECS[i].epen});
        if (VECS[i].erdr)
          check($sformatf("R4 R6 R7 R12 rpc v%0d", i), redirect_pc, VECS[i].erpc);
      end
    end

    // R11: low PC bits belong to the tag
    @(posedge clk);
    #2 drive(1'b1, 32'h140, 1'b1, 1'b0, 32'h300, 32'h140);
    @(posedge clk);
    #2 drive(1'b0, '0, 1'b0, 1'b0, '0, 32'h142);
    #9;
    check("R11 low-bit alias hit", {31'b0, pred_hit}, 32'd0);
    check("R11 low-bit alias next", pred_next_pc, 32'h146);

    // R9: resolve fields without res_valid have no effect
    @(posedge clk);
    #2 drive(1'b0, 32'h140, 1'b0, 1'b1, 32'h999, 32'h140);
    #9;
    check("R9 no redirect when idle", {31'b0, redirect}, 32'd0);
    check("R9 pvalid low", {31'b0, penalty_valid}, 32'd0);
    @(posedge clk);
    #2 drive(1'b0, '0, 1'b0, 1'b0, '0, 32'h140);
    #9;
    check("R9 table untouched hit", {31'b0, pred_hit}, 32'd1);
    check("R9 table untouched next", pred_next_pc, 32'h300);

    // R1: asynchronous reset clears the table
    #2 rst_ni = 1'b0;
    #1;
    check("R1 cleared hit", {31'b0, pred_hit}, 32'd0);
    check("R1 cleared next", pred_next_pc, 32'h144);
    @(posedge clk);
    #2 rst_ni = 1'b1;
    @(posedge clk);
    #9;
    check("R1 after release", {31'b0, pred_hit}, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule